// File: doc/BRIEF.md
# Latch-Addressed Floppy Register Port

This block is the bus-slave front end of a disk controller when the controller runs in its legacy personality. No access reaches a register directly. Every access, read or write, first sets or clears one of eight persistent control latches. The latch is chosen by the address, and the new latch value is the lowest index bit. Three of the updated latches then name one of eight logical registers. The stepper phase lines, motor enable and drive select come straight from the latch bank as outputs.

Reads return a fixed pattern that depends on the selected register. Writes that land on the mode register are watched for a four-write unlock pattern on a single data bit. When that pattern completes, the block raises a sticky enhanced-mode flag and sets the matching bit of the enhanced mode register. It also gives a one-cycle switch pulse, which downstream logic uses to swap in the second register map. From then on the legacy port ignores accesses until reset.

Top module: `floppy_latch_port`

## Requirements
- R1: After reset, ctl_latch is 8'h00, rd_data is 8'h00, enh_active is 0, enh_mode_reg is 8'h00 and switch_pulse is 0.
- R2: The access index is bus_addr[12:9], the address divided by a 512-byte stride. Index bits 3..1 name the latch, and index bit 0 is the value written to it. Address bits 8..0 have no effect.
- R3: Each accepted access, read or write, updates its latch. The new value shows on ctl_latch one clock after the access cycle, and the other seven latches keep their values. Latches 0..3 are stepper phases, latch 4 is motor enable and latch 5 is drive select.
- R4: The register number is {latch7, latch6, latch4}, formed from the latch values after the current access has updated them. 0 is all-ones, 1 is data, 2 and 3 are status, 4 and 5 are handshake, 6 is mode (write) and 7 is data (write).
- R5: A read that selects register 0 puts 8'hFF on rd_data one clock later. A read of any other register puts 8'h00 there. rd_data holds its value between reads.
- R6: Only writes that select register 6 step the unlock detector. The detector tests bit 6 of bus_wdata against the sequence 1, 0, 1, 1. Writes to other registers and all reads leave it alone.
- R7: A mode write whose bit 6 does not match the expected value leaves the detector at its current position. It does not restart the sequence.
- R8: The fourth matching mode write sets enh_active and enh_mode_reg[6] one clock after the write. switch_pulse is high for exactly that one clock, and the detector returns to its first position.
- R9: While enh_active is 1, accesses change no latch and reads put 8'h00 on rd_data. enh_active stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | One-cycle access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 13 | Byte address; bits 12..9 form the access index |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ctl_latch | output | 8 | Latch bank: phases 3..0, motor 4, drive select 5, mode latches 6 and 7 |
| enh_active | output | 1 | Enhanced personality selected |
| enh_mode_reg | output | 8 | Enhanced mode register image (bit 6 set on unlock) |
| switch_pulse | output | 1 | One-cycle pulse on entry to enhanced mode |

## Verification
The assertions assume that each access is a single-cycle bus_valid strobe. They also assume that bus_write, bus_addr and bus_wdata are stable and known at the clock edge where the strobe is high. The bench drives every input on the falling edge and spaces accesses two cycles apart, so it stays within those limits. To reach the mode register, it first sets latch 6 with a read, and then writes through the latch-7 set index. That index keeps the selection at register 6 without disturbing any other latch.

// File: rtl/floppy_latch_port.sv
module floppy_latch_port #(
  parameter int ADDR_W       = 13,
  parameter int STRIDE_SHIFT = 9,
  parameter int DATA_W       = 8,
  parameter int UNLOCK_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        ctl_latch,
  output logic              enh_active,
  output logic [DATA_W-1:0] enh_mode_reg,
  output logic              switch_pulse
);
  localparam int IDX_W    = 4;
  localparam int STEP_W   = 2;
  localparam logic [3:0] PATTERN = 4'b1101;
  localparam logic [2:0] REG_ONES = 3'd0;
  localparam logic [2:0] REG_MODE = 3'd6;

  logic [IDX_W-1:0]  idx;
  logic [7:0]        lat_nxt;
  logic [2:0]        reg_sel;
  logic [STEP_W-1:0] step;
  logic              take, mode_wr, hit, done;

  assign idx     = bus_addr[STRIDE_SHIFT +: IDX_W];
  assign take    = bus_valid && !enh_active;

  always_comb begin
    lat_nxt = ctl_latch;
    lat_nxt[idx[3:1]] = idx[0];
  end

  assign reg_sel = {lat_nxt[7], lat_nxt[6], lat_nxt[4]};
  assign mode_wr = take && bus_write && (reg_sel == REG_MODE);
  assign hit     = mode_wr && (bus_wdata[UNLOCK_BIT] == PATTERN[step]);
  assign done    = hit && (step == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_latch    <= '0;
      rd_data      <= '0;
      step         <= '0;
      enh_active   <= 1'b0;
      enh_mode_reg <= '0;
      switch_pulse <= 1'b0;
    end else begin
      switch_pulse <= done;
      if (take)
        ctl_latch <= lat_nxt;
      if (bus_valid && !bus_write)
        rd_data <= (take && reg_sel == REG_ONES) ? '1 : '0;
      if (hit)
        step <= done ? '0 : step + 2'd1;
      if (done) begin
        enh_active               <= 1'b1;
        enh_mode_reg[UNLOCK_BIT] <= 1'b1;
      end
    end
  end

  p_latch_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ctl_latch[$past(idx[3:1])] == $past(idx[0]));

  p_read_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bus_write) |=>
      ((rd_data == '1) == (ctl_latch[7:6] == 2'b00 && !ctl_latch[4])));

  p_pulse_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (enh_active && !$past(enh_active) && enh_mode_reg[UNLOCK_BIT]));

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |=> !switch_pulse);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enh_active |=> enh_active);

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_active && bus_valid) |=> $stable(ctl_latch));
endmodule

// File: tb/test_floppy_latch_port.sv
module test_floppy_latch_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [12:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  rd_data, ctl_latch, enh_mode_reg;
  logic        enh_active, switch_pulse;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_lat;
  logic [7:0] exp_rd;

  always #2.5 clk = ~clk;

  floppy_latch_port i_floppy_latch_port (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .ctl_latch(ctl_latch), .enh_active(enh_active),
    .enh_mode_reg(enh_mode_reg), .switch_pulse(switch_pulse));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    exp_lat = 8'h00; exp_rd = 8'h00;
  endtask

  task automatic access(input logic wr, input logic [3:0] idx, input logic [7:0] d,
                        input logic [8:0] junk);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = {idx, junk}; bus_wdata = d;
    if (!enh_active) exp_lat[idx[3:1]] = idx[0];
    if (!wr) exp_rd = (enh_active || exp_lat[7:6] != 2'b00 || exp_lat[4]) ? 8'h00 : 8'hFF;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic mode_wr(input logic b);
    access(1'b1, 4'hF, b ? 8'h40 : 8'hBF, 9'h000);
  endtask

  task automatic prep_mode;
    access(1'b0, 4'hD, 8'h00, 9'h000);
    access(1'b0, 4'h8, 8'h00, 9'h000);
  endtask

  task automatic t_reset;
    do_reset;
    check("R1 latch", ctl_latch, 8'h00);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 enh_active", enh_active, 0);
    check("R1 enh_mode_reg", enh_mode_reg, 8'h00);
    check("R1 switch_pulse", switch_pulse, 0);
  endtask

  task automatic t_decode;
    do_reset;
    access(1'b0, 4'h3, 8'h00, 9'h1FF);
    check("R2 index with low junk", ctl_latch, 8'h02);
    access(1'b1, 4'hB, 8'hFF, 9'h0A5);
    check("R2 latch5 set", ctl_latch, 8'h22);
    access(1'b0, 4'h2, 8'h00, 9'h155);
    check("R2 latch1 cleared", ctl_latch, 8'h20);
  endtask

  task automatic t_latches;
    do_reset;
    for (int i = 0; i < 8; i++) begin
      access(i[0], 4'((i << 1) | 1), 8'h00, 9'h000);
      check("R3 set walk", ctl_latch, exp_lat);
    end
    for (int i = 0; i < 8; i++) begin
      access(~i[0], 4'(i << 1), 8'h00, 9'h000);
      check("R3 clear walk", ctl_latch, exp_lat);
    end
  endtask

  task automatic t_select;
    do_reset;
    access(1'b0, 4'h1, 8'h00, 9'h000);
    check("R5 reg0 all ones", rd_data, 8'hFF);
    access(1'b0, 4'h9, 8'h00, 9'h000);
    check("R4 latch4 selects reg1 read zero", rd_data, 8'h00);
    access(1'b1, 4'h8, 8'h00, 9'h000);
    check("R5 write leaves rd_data", rd_data, 8'h00);
    access(1'b0, 4'h0, 8'h00, 9'h000);
    check("R4 update before select reg0", rd_data, 8'hFF);
    access(1'b1, 4'hD, 8'h00, 9'h000);
    check("R5 rd_data held across write", rd_data, 8'hFF);
    access(1'b0, 4'hC, 8'h00, 9'h000);
    check("R4 latch6 clear back to reg0", rd_data, exp_rd);
    access(1'b0, 4'hF, 8'h00, 9'h000);
    check("R4 latch7 selects reg4", rd_data, 8'h00);
  endtask

  task automatic t_unlock;
    do_reset;
    prep_mode;
    mode_wr(1); mode_wr(0); mode_wr(1);
    check("R6 three matches no unlock", enh_active, 0);
    mode_wr(1);
    check("R8 flag set", enh_active, 1);
    check("R8 pulse", switch_pulse, 1);
    check("R8 mode bit6", enh_mode_reg, 8'h40);
    @(negedge clk);
    check("R8 pulse one cycle", switch_pulse, 0);
    check("R9 flag stays", enh_active, 1);
  endtask

  task automatic t_mismatch;
    do_reset;
    prep_mode;
    mode_wr(1); mode_wr(1); mode_wr(1);
    check("R7 held at step1", enh_active, 0);
    mode_wr(0); mode_wr(0); mode_wr(1);
    check("R7 held at step3", enh_active, 0);
    mode_wr(1);
    check("R7 unlock after held steps", enh_active, 1);
  endtask

  task automatic t_other_regs;
    do_reset;
    prep_mode;
    mode_wr(1); mode_wr(0); mode_wr(1);
    access(1'b1, 4'h9, 8'h40, 9'h000);
    access(1'b0, 4'hF, 8'h00, 9'h000);
    access(1'b1, 4'hF, 8'h40, 9'h000);
    check("R6 reg7 write no step", enh_active, 0);
    access(1'b1, 4'h8, 8'h40, 9'h000);
    check("R6 final match unlocks", enh_active, 1);
  endtask

  task automatic t_frozen;
    check("R9 pre state", ctl_latch, 8'hC0);
    access(1'b0, 4'hC, 8'h00, 9'h000);
    check("R9 latch frozen", ctl_latch, 8'hC0);
    access(1'b0, 4'h8, 8'h00, 9'h000);
    check("R9 read returns zero", rd_data, 8'h00);
    access(1'b1, 4'h3, 8'hFF, 9'h000);
    check("R9 write ignored", ctl_latch, 8'hC0);
    check("R9 no new pulse", switch_pulse, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    exp_lat = '0; exp_rd = '0;
    t_reset;
    t_decode;
    t_latches;
    t_select;
    t_unlock;
    t_mismatch;
    t_other_regs;
    t_frozen;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule